// File: doc/BRIEF.md
# Two-Channel Bus Connection and Fault Controller

This block is the decision logic behind a two-way downstream bus switch. A master on the upstream two-wire bus issues a connect command carrying a two-bit channel mask. The block chooses which downstream channels actually close their switches. It enables the buffers between the two sides and drives a READY indication. Normally a channel is only joined when both of its lines read high at the instant of the command. An override bit lets the mask be applied regardless of the line levels.

The block also merges fault sources into one active-low, open-drain style alert output. The sources are the two per-channel alert inputs (synchronized and glitch filtered), the stuck-low timeout event, and failed connection attempts. Fault sources are grouped into two paths. A release from an alert-response or addressing event silences the alert. It does not sound again until a fault of a new kind rises, or a cleared fault appears afresh. A status-clear write empties the fault latches. Dropping the enable returns the switches and fault latches to their defaults, while channel alerts keep reaching the alert output.

Top module: `chsel_fault_ctrl`

## Requirements
- R1: After reset both switches are open, buffers disabled, ready_o low, fail_conn_n_o high, stuck_latched_o low, ch_alert_st_o = 2'b11 and alert_n_o high.
- R2: With conn_any_i = 0, a commanded channel that is not already connected closes only if its SDA and SCL both read high in the strobe cycle; otherwise it stays open.
- R3: When the mask names both channels (2'b11) and only one of them reads high, only that one is connected; mask bit 0 is channel 0 and bit 1 is channel 1.
- R4: With conn_any_i = 1, a strobe sets switch_on_o to the mask on the next cycle whatever the line levels, and never records a failed connection.
- R5: A strobe with conn_any_i = 0 that names an unconnected low channel drives fail_conn_n_o to 0 (0 means a failure occurred) on the next cycle, and alert_n_o goes low one cycle later.
- R6: ready_o is high exactly when at least one switch is closed; buf_enable_o is high only when a switch is closed and stuck_low_i is low.
- R7: A channel alert input held low long enough to pass the filter drives its ch_alert_st_o bit low and asserts alert_n_o.
- R8: A pulse on ara_done_i or dev_addressed_i while enabled releases alert_n_o; it stays released while the same faults persist and reasserts when a fault of another kind rises.
- R9: A status_clear_i pulse while enabled clears the failed-connection and stuck-low latches.
- R10: A rising stuck_low_i sets stuck_latched_o and asserts alert_n_o; further stuck events do not reassert the alert until the latch has been cleared.
- R11: With enable_i low the switches open, connect strobes, clears and releases are ignored, but a low channel alert still asserts alert_n_o.
- R12: A connected channel stays connected when a new command names it again, even if its lines now read low, and this records no failure.
- R13: A channel alert pulse shorter than FILT_CYC cycles leaves ch_alert_st_o and alert_n_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Enable; low restores defaults |
| cmd_strobe_i | input | 1 | One-cycle connect command strobe |
| cmd_mask_i | input | 2 | Requested switch states, bit i = channel i |
| conn_any_i | input | 1 | 1 = connect regardless of line levels |
| ch_sda_hi_i | input | 2 | Per-channel SDA reads high |
| ch_scl_hi_i | input | 2 | Per-channel SCL reads high |
| ch_alert_n_i | input | 2 | Per-channel alert, active low, asynchronous |
| stuck_low_i | input | 1 | Stuck-low timeout condition active |
| ara_done_i | input | 1 | Pulse: alert response answered |
| dev_addressed_i | input | 1 | Pulse: device addressed |
| status_clear_i | input | 1 | Pulse: status register written |
| switch_on_o | output | 2 | Switch states, 1 = closed |
| buf_enable_o | output | 1 | Upstream/downstream buffer enable |
| ready_o | output | 1 | High when any channel connected |
| fail_conn_n_o | output | 1 | 0 = failed connection attempt latched |
| stuck_latched_o | output | 1 | Stuck-low timeout latched |
| ch_alert_st_o | output | 2 | Filtered channel alert levels |
| alert_n_o | output | 1 | Shared alert, active low |

## Verification
Every cycle, the assertions check several local rules. A low channel is never closed without the override, and a forced strobe lands the mask. Connected channels survive a repeat command, and the switches open while disabled. A failed attempt or a rising source sets its latch, and clears and releases take effect. Buffer enable never appears without ready or during a stuck condition. The filtered alert only ever takes a value its synchronizer presented. Only the bench's scenarios, compared against its cycle model, show the longer chains: the suppression of alert after a release while the same fault lingers, its return on a new fault type, the once-only stuck latch until cleared, filter rejection of short pulses, and alert reaching the output while disabled.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    localparam int unsigned NCH = 2;

    // bit index of each fault source inside fault_vec_t
    typedef enum logic [1:0] {
        SRC_CONN  = 2'd0,
        SRC_AL0   = 2'd1,
        SRC_AL1   = 2'd2,
        SRC_STUCK = 2'd3
    } fault_src_e;

    typedef struct packed {
        logic stuck;
        logic al1;
        logic al0;
        logic conn;
    } fault_vec_t;

    typedef struct packed {
        logic            strobe;
        logic            force_conn;
        logic [NCH-1:0]  mask;
    } conn_cmd_t;

    typedef struct packed {
        logic ara;
        logic addr;
        logic clr;
    } bus_evt_t;

    function automatic logic chan_idle(input logic sda_hi, input logic scl_hi);
        return sda_hi & scl_hi;
    endfunction

    // sources that share the first alert path
    function automatic logic shared_path(input fault_vec_t v);
        return v.conn | v.al0 | v.al1;
    endfunction

endpackage

// File: rtl/chsel_alert_filt.sv
module chsel_alert_filt #(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic alert_n_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic          s1_q, s2_q, lvl_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            lvl_q <= 1'b1;
            run_q <= '0;
        end else begin
            s1_q <= alert_n_i;
            s2_q <= s1_q;
            if (s2_q != lvl_q) begin
                if (run_q == LAST) begin
                    lvl_q <= s2_q;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign level_o = lvl_q;

    // R13: the filtered level only ever takes a value the synchronizer presented
    p_filt_source_r13: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> (lvl_q == $past(s2_q)));

endmodule

// File: rtl/chsel_conn_ctrl.sv
module chsel_conn_ctrl
    import chsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  conn_cmd_t       cmd,
    input  logic [NCH-1:0]  ch_hi,
    output logic [NCH-1:0]  sw_o,
    output logic            fail_evt_o
);
    logic [NCH-1:0] sw_q, sw_nxt, bad;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            bad[i] = 1'b0;
            if (cmd.force_conn) begin
                sw_nxt[i] = cmd.mask[i];
            end else begin
                sw_nxt[i] = cmd.mask[i] & (sw_q[i] | ch_hi[i]);
                bad[i]    = cmd.mask[i] & ~sw_q[i] & ~ch_hi[i];
            end
        end

        // R2: a low, unconnected channel is not closed without the override
        p_no_low_conn_r2: assert property (@(posedge clk) disable iff (rst)
            (en && cmd.strobe && !cmd.force_conn && cmd.mask[i] && !sw_q[i] && !ch_hi[i])
            |=> !sw_q[i]);

        // R12: a connected channel named again stays connected
        p_keep_conn_r12: assert property (@(posedge clk) disable iff (rst)
            (en && cmd.strobe && !cmd.force_conn && cmd.mask[i] && sw_q[i]) |=> sw_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sw_q <= '0;
        end else if (cmd.strobe) begin
            sw_q <= sw_nxt;
        end
    end

    assign sw_o       = sw_q;
    assign fail_evt_o = en & cmd.strobe & (|bad);

    // R4: forced command lands the mask
    p_force_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (en && cmd.strobe && cmd.force_conn) |=> (sw_q == $past(cmd.mask)));

    // R11: switches open while disabled
    p_dis_open_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sw_q == '0));

endmodule

// File: rtl/chsel_fault_unit.sv
module chsel_fault_unit
    import chsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            fail_evt,
    input  logic            stuck,
    input  logic [NCH-1:0]  ch_lvl,
    input  bus_evt_t        evt,
    output logic            fail_lat_o,
    output logic            stuck_lat_o,
    output logic            alert_n_o
);
    logic       fail_q, stk_lat_q, stk_prev_q, act_sh_q, act_st_q;
    fault_vec_t lvl, prev_q, rise;
    logic       release_ev, stk_rise;

    always_comb begin
        lvl.conn  = fail_q;
        lvl.al0   = ~ch_lvl[0];
        lvl.al1   = ~ch_lvl[1];
        lvl.stuck = stk_lat_q;
        rise      = lvl & ~prev_q;
    end

    assign release_ev = en & (evt.ara | evt.addr);
    assign stk_rise   = en & stuck & ~stk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q     <= 1'b0;
            stk_lat_q  <= 1'b0;
            stk_prev_q <= 1'b0;
            prev_q     <= '0;
            act_sh_q   <= 1'b0;
            act_st_q   <= 1'b0;
        end else begin
            stk_prev_q <= stuck;
            prev_q     <= lvl;

            if (!en)           fail_q <= 1'b0;
            else if (fail_evt) fail_q <= 1'b1;
            else if (evt.clr)  fail_q <= 1'b0;

            if (!en)           stk_lat_q <= 1'b0;
            else if (stk_rise) stk_lat_q <= 1'b1;
            else if (evt.clr)  stk_lat_q <= 1'b0;

            if (shared_path(rise))                   act_sh_q <= 1'b1;
            else if (!shared_path(lvl) || release_ev) act_sh_q <= 1'b0;

            if (rise.stuck)                    act_st_q <= 1'b1;
            else if (!lvl.stuck || release_ev) act_st_q <= 1'b0;
        end
    end

    assign fail_lat_o  = fail_q;
    assign stuck_lat_o = stk_lat_q;
    assign alert_n_o   = ~(act_sh_q | act_st_q);

    // R5: a failed attempt is latched on the next cycle
    p_fail_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (en && fail_evt) |=> fail_q);

    // R9: a clear empties the latches unless a new event arrives together
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (en && evt.clr && !fail_evt && !stk_rise) |=> (!fail_q && !stk_lat_q));

    // R7: a newly rising source in the shared path asserts the alert
    p_rise_alert_r7: assert property (@(posedge clk) disable iff (rst)
        shared_path(rise) |=> !alert_n_o);

    // R8: a release with no new rise silences the alert
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (release_ev && (rise == '0)) |=> alert_n_o);

    // R10: the stuck latch sets on a rising stuck condition
    p_stuck_set_r10: assert property (@(posedge clk) disable iff (rst)
        stk_rise |=> stk_lat_q);

endmodule

// File: rtl/chsel_fault_ctrl.sv
module chsel_fault_ctrl
    import chsel_pkg::*;
#(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable_i,
    input  logic       cmd_strobe_i,
    input  logic [1:0] cmd_mask_i,
    input  logic       conn_any_i,
    input  logic [1:0] ch_sda_hi_i,
    input  logic [1:0] ch_scl_hi_i,
    input  logic [1:0] ch_alert_n_i,
    input  logic       stuck_low_i,
    input  logic       ara_done_i,
    input  logic       dev_addressed_i,
    input  logic       status_clear_i,
    output logic [1:0] switch_on_o,
    output logic       buf_enable_o,
    output logic       ready_o,
    output logic       fail_conn_n_o,
    output logic       stuck_latched_o,
    output logic [1:0] ch_alert_st_o,
    output logic       alert_n_o
);
    conn_cmd_t      cmd;
    bus_evt_t       evt;
    logic [NCH-1:0] ch_hi, ch_lvl, sw;
    logic           fail_evt, fail_lat;

    assign cmd = '{strobe: cmd_strobe_i, force_conn: conn_any_i, mask: cmd_mask_i};
    assign evt = '{ara: ara_done_i, addr: dev_addressed_i, clr: status_clear_i};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_hi[i] = chan_idle(ch_sda_hi_i[i], ch_scl_hi_i[i]);

        chsel_alert_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk       (clk),
            .rst       (rst),
            .alert_n_i (ch_alert_n_i[i]),
            .level_o   (ch_lvl[i])
        );
    end

    chsel_conn_ctrl u_conn (
        .clk        (clk),
        .rst        (rst),
        .en         (enable_i),
        .cmd        (cmd),
        .ch_hi      (ch_hi),
        .sw_o       (sw),
        .fail_evt_o (fail_evt)
    );

    chsel_fault_unit u_fault (
        .clk         (clk),
        .rst         (rst),
        .en          (enable_i),
        .fail_evt    (fail_evt),
        .stuck       (stuck_low_i),
        .ch_lvl      (ch_lvl),
        .evt         (evt),
        .fail_lat_o  (fail_lat),
        .stuck_lat_o (stuck_latched_o),
        .alert_n_o   (alert_n_o)
    );

    assign switch_on_o   = sw;
    assign ready_o       = |sw;
    assign buf_enable_o  = (|sw) & ~stuck_low_i;
    assign fail_conn_n_o = ~fail_lat;
    assign ch_alert_st_o = ch_lvl;

    // R6: buffers only run with a connected channel and no stuck condition
    p_buf_ready_r6: assert property (@(posedge clk) disable iff (rst)
        buf_enable_o |-> (ready_o && !stuck_low_i));

    // R4: a forced command never records a failure
    p_force_nofail_r4: assert property (@(posedge clk) disable iff (rst)
        (enable_i && cmd_strobe_i && conn_any_i) |=> $stable(fail_conn_n_o) || fail_conn_n_o);

endmodule

// File: tb/chsel_fault_ctrl_tb.sv
module chsel_fault_ctrl_tb_top;
    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1, strobe = 1'b0, any = 1'b0;
    logic [1:0] mask = 2'b00, sda = 2'b11, scl = 2'b11, aln = 2'b11;
    logic stuck = 1'b0, ara = 1'b0, addr = 1'b0, clr = 1'b0;

    logic [1:0] sw_o, chst_o;
    logic bufen_o, rdy_o, failn_o, stk_o, alertn_o;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chsel_fault_ctrl #(.FILT_CYC(FILT)) dut_i (
        .clk(clk), .rst(rst), .enable_i(en), .cmd_strobe_i(strobe), .cmd_mask_i(mask),
        .conn_any_i(any), .ch_sda_hi_i(sda), .ch_scl_hi_i(scl), .ch_alert_n_i(aln),
        .stuck_low_i(stuck), .ara_done_i(ara), .dev_addressed_i(addr),
        .status_clear_i(clr), .switch_on_o(sw_o), .buf_enable_o(bufen_o),
        .ready_o(rdy_o), .fail_conn_n_o(failn_o), .stuck_latched_o(stk_o),
        .ch_alert_st_o(chst_o), .alert_n_o(alertn_o));

    // behavioural reference model
    int m_sw[2], m_s1[2], m_s2[2], m_lv[2], m_run[2];
    int m_fail, m_stk, m_stq, m_shared, m_stpath;
    int m_pconn, m_pal0, m_pal1, m_pstk;

    always @(posedge clk) begin
        int n_sw[2];
        int lconn, lal0, lal1, lstk, rshared, rstk, rel, bad;
        if (rst) begin
            foreach (m_sw[i]) begin
                m_sw[i] = 0; m_s1[i] = 1; m_s2[i] = 1; m_lv[i] = 1; m_run[i] = 0;
            end
            m_fail = 0; m_stk = 0; m_stq = 0; m_shared = 0; m_stpath = 0;
            m_pconn = 0; m_pal0 = 0; m_pal1 = 0; m_pstk = 0;
        end else begin
            lconn = m_fail; lal0 = !m_lv[0]; lal1 = !m_lv[1]; lstk = m_stk;
            rshared = (lconn && !m_pconn) || (lal0 && !m_pal0) || (lal1 && !m_pal1);
            rstk = lstk && !m_pstk;
            rel = en && (ara || addr);
            if (rshared) m_shared = 1;
            else if (!(lconn || lal0 || lal1) || rel) m_shared = 0;
            if (rstk) m_stpath = 1;
            else if (!lstk || rel) m_stpath = 0;
            m_pconn = lconn; m_pal0 = lal0; m_pal1 = lal1; m_pstk = lstk;

            bad = 0;
            for (int i = 0; i < 2; i++) begin
                n_sw[i] = m_sw[i];
                if (strobe) begin
                    if (any) n_sw[i] = mask[i];
                    else if (!mask[i]) n_sw[i] = 0;
                    else if (m_sw[i]) n_sw[i] = 1;
                    else if (sda[i] && scl[i]) n_sw[i] = 1;
                    else begin n_sw[i] = 0; bad = 1; end
                end
                if (!en) n_sw[i] = 0;
            end
            if (!en) m_fail = 0;
            else if (strobe && bad) m_fail = 1;
            else if (clr) m_fail = 0;
            if (!en) m_stk = 0;
            else if (stuck && !m_stq) m_stk = 1;
            else if (clr) m_stk = 0;
            m_stq = stuck;
            m_sw = n_sw;

            for (int i = 0; i < 2; i++) begin
                if (m_s2[i] != m_lv[i]) begin
                    if (m_run[i] == FILT - 1) begin m_lv[i] = m_s2[i]; m_run[i] = 0; end
                    else m_run[i]++;
                end else m_run[i] = 0;
                m_s2[i] = m_s1[i];
                m_s1[i] = aln[i];
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 R3 R4 R12 R11", "switch_on", sw_o, {m_sw[1][0], m_sw[0][0]});
            chk("R6", "ready", rdy_o, (m_sw[0] || m_sw[1]) ? 1 : 0);
            chk("R6", "buf_enable", bufen_o, ((m_sw[0] || m_sw[1]) && !stuck) ? 1 : 0);
            chk("R5 R9", "fail_conn_n", failn_o, !m_fail);
            chk("R10", "stuck_latched", stk_o, m_stk);
            chk("R7 R13", "ch_alert_st", chst_o, {m_lv[1][0], m_lv[0][0]});
            chk("R8", "alert_n", alertn_o, !(m_shared || m_stpath));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            strobe = 0; ara = 0; addr = 0; clr = 0;
        end
    endtask

    task automatic cmd(input logic [1:0] m, input logic f);
        mask = m; any = f; strobe = 1; tick(1);
    endtask

    initial begin
        tick(3);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1", "sw", sw_o, 0); chk("R1", "ready", rdy_o, 0); chk("R1", "buf", bufen_o, 0);
        chk("R1", "failn", failn_o, 1); chk("R1", "stk", stk_o, 0);
        chk("R1", "chst", chst_o, 3); chk("R1", "alert", alertn_o, 1);

        // R2 and R5: low channel 0 refused, fault recorded and alerted
        sda = 2'b10; cmd(2'b01, 0); tick(3);
        chk("R2", "ch0 open", sw_o, 0); chk("R5", "failn", failn_o, 0); chk("R5", "alert", alertn_o, 0);
        // R8 release, stays quiet while fault latched
        ara = 1; tick(4);
        chk("R8", "released", alertn_o, 1); chk("R8", "failn kept", failn_o, 0);
        // R9 clear
        clr = 1; tick(2); chk("R9", "cleared", failn_o, 1);

        // R3: both named, only channel 1 high
        cmd(2'b11, 0); tick(3);
        chk("R3", "only ch1", sw_o, 2'b10); chk("R6", "ready", rdy_o, 1); chk("R6", "buf", bufen_o, 1);
        clr = 1; tick(3);

        // R12: ch1 connected goes low, command re-names it with ch0 now high
        sda = 2'b01; cmd(2'b11, 0); tick(3);
        chk("R12", "both kept", sw_o, 2'b11); chk("R12", "no fail", failn_o, 1);

        // R4: override applies mask over low lines
        sda = 2'b00; scl = 2'b00; cmd(2'b01, 1); tick(2);
        chk("R4", "forced", sw_o, 2'b01); chk("R4", "no fail", failn_o, 1);
        sda = 2'b11; scl = 2'b11;

        // R6 and R10: stuck condition
        stuck = 1; tick(3);
        chk("R6", "buf off", bufen_o, 0); chk("R6", "ready on", rdy_o, 1);
        chk("R10", "latched", stk_o, 1); chk("R10", "alert", alertn_o, 0);
        addr = 1; tick(2); chk("R8", "addr release", alertn_o, 1);
        stuck = 0; tick(2); stuck = 1; tick(3);
        chk("R10", "no reassert", alertn_o, 1);
        clr = 1; tick(2); stuck = 0; tick(2); stuck = 1; tick(3);
        chk("R10", "reassert after clear", alertn_o, 0);
        ara = 1; stuck = 0; tick(3);

        // R13: short pulse rejected
        aln = 2'b01; tick(FILT - 2); aln = 2'b11; tick(10);
        chk("R13", "short", chst_o, 3); chk("R13", "no alert", alertn_o, 1);
        // R7: long low passes
        aln = 2'b01; tick(FILT + 5);
        chk("R7", "ch1 low", chst_o, 2'b01); chk("R7", "alert", alertn_o, 0);
        addr = 1; tick(2); chk("R8", "released", alertn_o, 1);
        aln = 2'b00; tick(FILT + 5); chk("R8", "new type reasserts", alertn_o, 0);
        aln = 2'b11; tick(FILT + 5); chk("R7", "cleared by source", alertn_o, 1);

        // R11: disabled
        en = 0; tick(2); chk("R11", "open", sw_o, 0);
        cmd(2'b11, 1); tick(2); chk("R11", "strobe ignored", sw_o, 0);
        aln = 2'b10; tick(FILT + 5); chk("R11", "alert while off", alertn_o, 0);
        ara = 1; tick(2); chk("R11", "release ignored", alertn_o, 0);
        aln = 2'b11; tick(FILT + 5); en = 1; tick(2);

        // random traffic compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            sda = 2'($urandom); scl = 2'($urandom | $urandom);
            mask = 2'($urandom); any = ($urandom % 4) == 0;
            strobe = ($urandom % 6) == 0;
            if (($urandom % 20) == 0) aln[$urandom % 2] = ~aln[0];
            if (($urandom % 30) == 0) stuck = ~stuck;
            ara = ($urandom % 25) == 0; addr = ($urandom % 40) == 0;
            clr = ($urandom % 30) == 0; en = ($urandom % 50) != 0;
            @(posedge clk); #1;
        end
        en = 1; tick(5);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule